// File: doc/BRIEF.md
# Timer Channel Status Flags and Interrupt Enables

This block holds the event flags and interrupt enables for one channel of a 16-bit general-purpose timer. There are three event flags. Flag A records an event on general register A. Flag B records an event on general register B. The overflow flag records a counter overflow pulse. For each general register, a mode input selects the source of its event. In compare mode the event is the counter value equalling the register. In capture mode the event is the capture strobe.

Both the flags and the enable register are reached over a byte-wide CPU bus with a one-bit register select. A flag can be cleared in only one way: the CPU first reads it while it is 1, and then writes 0 to its bit. Each interrupt request output is a level. A DMA request follows the A interrupt on channels 0 to 3 and is tied low on channel 4.

Top module: `tmr_stat_irq`

## Requirements
- R1: With `cap_mode_a` = 0, a cycle in which `cnt_val` equals `gra_val` sets flag A (status bit 0). The flag reads 1 from the following cycle on.
- R2: With `cap_mode_a` = 1, a `cap_strobe_a` pulse sets flag A. A counter match in this mode does not set it.
- R3: A status write (`cpu_sel` = 0) that puts 0 in a flag's bit clears that flag only if an earlier status read saw that flag at 1. A 0 write with no such read leaves the flag at 1. Writing 1 to a flag bit never changes the flag.
- R4: Each flag has its own arming. A status read that sees a flag at 0 does not arm that flag's clear.
- R5: If a flag's set condition and a valid clear write fall in the same cycle, the flag stays 1.
- R6: Flag B (status bit 1) follows `grb_val`, `cap_mode_b` and `cap_strobe_b` under the rules of R1 to R5. The overflow flag (status bit 2) is set by `ovf_pulse` and obeys the same clear rule. Status bits 7 to 3 read 0.
- R7: `irq_a`, `irq_b` and `irq_ovf` are each the AND of a flag and its enable bit. Enable bit 0 belongs to A, bit 1 to B and bit 2 to overflow. Each request stays high until the flag clears or its enable drops.
- R8: `dma_req_a` equals `irq_a` when CHAN is 0 to 3, and is 0 when CHAN is 4.
- R9: The enable register is read and written with `cpu_sel` = 1. Bits 6 to 3 always read 1, and bit 7 reads the TOP_BIT parameter. Writes change only bits 2 to 0. After reset it reads 0xF8 (TOP_BIT = 1) or 0x78 (TOP_BIT = 0).
- R10: While `standby` is high, the enable bits return to 0 and CPU writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Holds the enable register at its initial value |
| cpu_sel | input | 1 | Register select: 0 status, 1 enable |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the selected register |
| cnt_val | input | 16 | Counter value |
| gra_val | input | 16 | General register A value |
| grb_val | input | 16 | General register B value |
| cap_mode_a | input | 1 | 1 = register A in capture mode |
| cap_mode_b | input | 1 | 1 = register B in capture mode |
| cap_strobe_a | input | 1 | Capture strobe for register A |
| cap_strobe_b | input | 1 | Capture strobe for register B |
| ovf_pulse | input | 1 | Counter overflow pulse |
| irq_a | output | 1 | Compare/capture A interrupt request |
| irq_b | output | 1 | Compare/capture B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| dma_req_a | output | 1 | DMA request from compare/capture A |

## Verification
The bench builds two instances that take the same stimulus. One uses CHAN = 1 and TOP_BIT = 1. The other uses CHAN = 4 and TOP_BIT = 0. The first instance exercises the live DMA request and the 0xF8 enable pattern. The second checks that the DMA request is held low and that the enable register reads 0x78. Because both instances share every bus cycle, any difference between their flags or requests shows up against the same expected values.

// File: rtl/tsi_pkg.sv
// Shared constants for the timer status/enable unit.
// Assumes three event flags, in a fixed bit order that the CPU decodes.
package tsi_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int IDX_A     = 0;
    localparam int IDX_B     = 1;
    localparam int IDX_OVF   = 2;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 16;
    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_ENABLE = 1'b1;
endpackage

// File: rtl/tsi_event.sv
// Event detector for one general register.
// In compare mode it reports counter == register.
// In capture mode it reports the capture strobe.
// Assumes the strobe is already synchronous to clk.
module tsi_event #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] greg,
    input  logic         cap_mode,
    input  logic         strobe,
    output logic         hit
);
    // Select the event source by mode
    always_comb begin
        if (cap_mode) hit = strobe;
        else          hit = (cnt == greg);
    end
endmodule

// File: rtl/tsi_flag.sv
// One status flag with a read-then-write-0 clear.
// A read that sees the flag at 1 arms the clear. A later write of 0 then clears it.
// A set in the same cycle as the clear wins.
// Assumes rd_stat and wr_zero are single-cycle qualified strobes.
module tsi_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_stat,
    input  logic wr_zero,
    output logic flag
);
    logic armed;

    // Flag state: set has priority over an armed clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (set_ev)             flag <= 1'b1;
        else if (wr_zero && armed)   flag <= 1'b0;
    end

    // Arm state: captured from the flag on each status read, dropped once the flag is cleared
    always_ff @(posedge clk) begin
        if (!rst_n)                  armed <= 1'b0;
        else if (rd_stat)            armed <= flag;
        else if (wr_zero && armed && !set_ev) armed <= 1'b0;
    end
endmodule

// File: rtl/tsi_enable.sv
// Interrupt enable register: three live bits plus fixed upper bits.
// While standby is high it is forced back to its initial value.
// Assumes wr is already qualified by the register select.
module tsi_enable #(
    parameter int    NB      = 3,
    parameter int    DW      = 8,
    parameter logic  TOP_BIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          wr,
    input  logic [NB-1:0] wdata,
    output logic [NB-1:0] en,
    output logic [DW-1:0] rd_view
);
    localparam int FILL_W = DW - NB - 1;

    // Live enable bits: cleared by reset or standby, otherwise loaded by writes
    always_ff @(posedge clk) begin
        if (!rst_n || standby) en <= '0;
        else if (wr)           en <= wdata;
    end

    // Read view: the fixed top bit, the ones fill, then the live bits
    always_comb begin
        rd_view = {TOP_BIT, {FILL_W{1'b1}}, en};
    end
endmodule

// File: rtl/tmr_stat_irq.sv
// Status flags and interrupt enables for one timer channel.
// The CPU reaches the status register with sel=0 and the enable register with sel=1.
// Interrupt requests are levels. A DMA request follows A on channels 0..3.
// Assumes one-cycle rd/wr strobes and synchronous event inputs.
module tmr_stat_irq #(
    parameter int   CHAN    = 1,
    parameter logic TOP_BIT = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      standby,
    input  logic                      cpu_sel,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  logic [tsi_pkg::DATA_W-1:0] cpu_wdata,
    output logic [tsi_pkg::DATA_W-1:0] cpu_rdata,
    input  logic [tsi_pkg::CNT_W-1:0]  cnt_val,
    input  logic [tsi_pkg::CNT_W-1:0]  gra_val,
    input  logic [tsi_pkg::CNT_W-1:0]  grb_val,
    input  logic                      cap_mode_a,
    input  logic                      cap_mode_b,
    input  logic                      cap_strobe_a,
    input  logic                      cap_strobe_b,
    input  logic                      ovf_pulse,
    output logic                      irq_a,
    output logic                      irq_b,
    output logic                      irq_ovf,
    output logic                      dma_req_a
);
    import tsi_pkg::*;

    localparam int PAD_W = DATA_W - NUM_FLAGS;

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] ien;
    logic [DATA_W-1:0]    ien_view;
    logic                 rd_stat;
    logic                 wr_stat;
    logic                 wr_en;
    logic [NUM_FLAGS-1:0] gr_mode;
    logic [NUM_FLAGS-1:0] gr_strobe;
    logic [CNT_W-1:0]     gr_val [NUM_FLAGS-1];

    // Decode bus strobes by register select
    always_comb begin
        rd_stat = cpu_rd && (cpu_sel == SEL_STATUS);
        wr_stat = cpu_wr && (cpu_sel == SEL_STATUS);
        wr_en   = cpu_wr && (cpu_sel == SEL_ENABLE);
    end

    // Gather general-register inputs into arrays for the generate loop
    always_comb begin
        gr_val[IDX_A]    = gra_val;
        gr_val[IDX_B]    = grb_val;
        gr_mode          = {1'b0, cap_mode_b, cap_mode_a};
        gr_strobe        = {1'b0, cap_strobe_b, cap_strobe_a};
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            if (gi == IDX_OVF) begin : g_ovf
                // Overflow source is the pulse itself
                always_comb set_vec[gi] = ovf_pulse;
            end else begin : g_greg
                tsi_event #(.W(CNT_W)) u_ev (
                    .cnt      (cnt_val),
                    .greg     (gr_val[gi]),
                    .cap_mode (gr_mode[gi]),
                    .strobe   (gr_strobe[gi]),
                    .hit      (set_vec[gi])
                );
            end
            tsi_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_ev  (set_vec[gi]),
                .rd_stat (rd_stat),
                .wr_zero (wr_stat && !cpu_wdata[gi]),
                .flag    (flags[gi])
            );
        end
    endgenerate

    tsi_enable #(.NB(NUM_FLAGS), .DW(DATA_W), .TOP_BIT(TOP_BIT)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .wr      (wr_en),
        .wdata   (cpu_wdata[NUM_FLAGS-1:0]),
        .en      (ien),
        .rd_view (ien_view)
    );

    // Read mux: status flags under zero padding, or the enable view
    always_comb begin
        if (cpu_sel == SEL_ENABLE) cpu_rdata = ien_view;
        else                       cpu_rdata = {{PAD_W{1'b0}}, flags};
    end

    // Level interrupt requests
    always_comb begin
        irq_a   = flags[IDX_A]   && ien[IDX_A];
        irq_b   = flags[IDX_B]   && ien[IDX_B];
        irq_ovf = flags[IDX_OVF] && ien[IDX_OVF];
    end

    // DMA request exists only on the lower channels
    generate
        if (CHAN <= 3) begin : g_dma
            always_comb dma_req_a = irq_a;
        end else begin : g_nodma
            always_comb dma_req_a = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/tsi_chk.sv
// Property checker for tmr_stat_irq, attached by bind.
// Assumes it observes the top's internal flag and enable vectors.
module tsi_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        standby,
    input logic        cpu_sel,
    input logic        cpu_wr,
    input logic [7:0]  cpu_wdata,
    input logic [15:0] cnt_val,
    input logic [15:0] gra_val,
    input logic        cap_mode_a,
    input logic        cap_strobe_a,
    input logic        ovf_pulse,
    input logic [2:0]  flags,
    input logic [2:0]  ien,
    input logic        irq_a,
    input logic        dma_req_a
);
    a_r1_compare_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mode_a && cnt_val == gra_val) |=> flags[0]);

    a_r2_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_a && cap_strobe_a) |=> flags[0]);

    a_r2_no_match_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_a && !cap_strobe_a && !flags[0]) |=> !flags[0]);

    a_r3_hold_without_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(cpu_wr && !cpu_sel && !cpu_wdata[0])) |=> flags[0]);

    a_r6_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> flags[2]);

    a_r8_dma_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_a |-> irq_a);

    a_r10_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (ien == 3'b000));
endmodule

bind tmr_stat_irq tsi_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby      (standby),
    .cpu_sel      (cpu_sel),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .cnt_val      (cnt_val),
    .gra_val      (gra_val),
    .cap_mode_a   (cap_mode_a),
    .cap_strobe_a (cap_strobe_a),
    .ovf_pulse    (ovf_pulse),
    .flags        (flags),
    .ien          (ien),
    .irq_a        (irq_a),
    .dma_req_a    (dma_req_a)
);

// File: tb/sim_tmr_stat_irq.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares them at negedge.
module sim_tmr_stat_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [15:0] cnt_val = '0;
    logic [15:0] gra_val = 16'h1234;
    logic [15:0] grb_val = 16'h0040;
    logic        cap_mode_a = 1'b0;
    logic        cap_mode_b = 1'b0;
    logic        cap_strobe_a = 1'b0;
    logic        cap_strobe_b = 1'b0;
    logic        ovf_pulse = 1'b0;

    logic [7:0] rd0, rd1;
    logic ia0, ib0, io0, dm0, ia1, ib1, io1, dm1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int         src;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    tmr_stat_irq #(.CHAN(1), .TOP_BIT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_sel(cpu_sel),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rd0),
        .cnt_val(cnt_val), .gra_val(gra_val), .grb_val(grb_val),
        .cap_mode_a(cap_mode_a), .cap_mode_b(cap_mode_b),
        .cap_strobe_a(cap_strobe_a), .cap_strobe_b(cap_strobe_b),
        .ovf_pulse(ovf_pulse), .irq_a(ia0), .irq_b(ib0), .irq_ovf(io0), .dma_req_a(dm0));

    tmr_stat_irq #(.CHAN(4), .TOP_BIT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_sel(cpu_sel),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(rd1),
        .cnt_val(cnt_val), .gra_val(gra_val), .grb_val(grb_val),
        .cap_mode_a(cap_mode_a), .cap_mode_b(cap_mode_b),
        .cap_strobe_a(cap_strobe_a), .cap_strobe_b(cap_strobe_b),
        .ovf_pulse(ovf_pulse), .irq_a(ia1), .irq_b(ib1), .irq_ovf(io1), .dma_req_a(dm1));

    // Observed value for a scoreboard source code
    function automatic logic [7:0] observe(int src);
        case (src)
            0: return rd0;
            1: return {5'b0, io0, ib0, ia0};
            2: return {6'b0, dm0, dm1};
            3: return rd1;
            default: return {5'b0, io1, ib1, ia1};
        endcase
    endfunction

    // Monitor: pop and compare queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = observe(it.src);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s src%0d actual=%02h expected=%02h", it.req, it.src, act, it.exp);
                end
            end
        end
    end

    // Advance to just after the next rising edge
    task automatic cyc();
        @(posedge clk); #1;
        cpu_rd = 0; cpu_wr = 0; cap_strobe_a = 0; cap_strobe_b = 0; ovf_pulse = 0; standby = 0;
    endtask

    // Queue an expectation against the current settled outputs
    task automatic expect_(int src, logic [7:0] e, string req);
        item_t it;
        it.src = src; it.exp = e; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Drive a status read pulse and check the returned data
    task automatic rd_stat(logic [7:0] e, string req);
        cpu_sel = 0; cpu_rd = 1;
        expect_(0, e, req);
        cyc();
    endtask

    task automatic wr_reg(logic sel, logic [7:0] d);
        cpu_sel = sel; cpu_wr = 1; cpu_wdata = d;
        cyc();
    endtask

    task automatic peek(logic sel, int src, logic [7:0] e, string req);
        cpu_sel = sel;
        expect_(src, e, req);
    endtask

    initial begin
        #20000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc(); rst_n = 1; cyc();
        // Reset state
        peek(1, 0, 8'hF8, "R9 reset enable u0");
        peek(1, 3, 8'h78, "R9 reset enable u1");
        peek(0, 0, 8'h00, "R6 reset status");
        peek(0, 1, 8'h00, "R7 reset irq");

        // R1 compare match on A
        cnt_val = 16'h1234; cyc(); cnt_val = 16'h0000;
        peek(0, 0, 8'h01, "R1 compare sets A");
        peek(0, 1, 8'h00, "R7 irq masked");

        // R9 upper enable bits ignore writes
        wr_reg(1, 8'h00);
        peek(1, 0, 8'hF8, "R9 write zero upper");
        wr_reg(1, 8'hFF);
        peek(1, 0, 8'hFF, "R9 write ones");
        peek(1, 3, 8'h7F, "R9 u1 top bit");
        wr_reg(1, 8'h01);
        peek(0, 1, 8'h01, "R7 irq_a level");
        peek(0, 2, 8'h02, "R8 dma only on low channel");

        // R3 zero write without prior read is ignored; writing 1 too
        wr_reg(0, 8'h00);
        peek(0, 0, 8'h01, "R3 unarmed zero write");
        rd_stat(8'h01, "R3 read while set");
        wr_reg(0, 8'hFF);
        peek(0, 0, 8'h01, "R3 one write no clear");
        wr_reg(0, 8'h00);
        peek(0, 0, 8'h00, "R3 armed clear");
        peek(0, 2, 8'h00, "R8 dma drops");

        // R4 read seeing 0 does not arm
        rd_stat(8'h00, "R4 read sees zero");
        cnt_val = 16'h1234; cyc(); cnt_val = 16'h0000;
        wr_reg(0, 8'h00);
        peek(0, 0, 8'h01, "R4 not armed");
        rd_stat(8'h01, "R4 arm"); wr_reg(0, 8'h00);

        // R2 capture mode: match ignored, strobe sets
        cap_mode_a = 1; cnt_val = 16'h1234; cyc(); cnt_val = 16'h0000;
        peek(0, 0, 8'h00, "R2 match ignored in capture");
        cap_strobe_a = 1; cyc();
        peek(0, 0, 8'h01, "R2 strobe sets");

        // R5 set wins over armed clear
        rd_stat(8'h01, "R5 arm");
        cap_strobe_a = 1; cpu_sel = 0; cpu_wr = 1; cpu_wdata = 8'h00; cyc();
        peek(0, 0, 8'h01, "R5 set wins");

        // R6 B and overflow
        ovf_pulse = 1; cnt_val = 16'h0040; cyc(); cnt_val = 16'h0000;
        peek(0, 0, 8'h07, "R6 B and ovf set");
        wr_reg(1, 8'h06);
        peek(0, 1, 8'h06, "R7 irq_b irq_ovf");
        peek(0, 4, 8'h06, "R7 u1 irq");
        rd_stat(8'h07, "R6 arm all");
        wr_reg(0, 8'hFD);
        peek(0, 0, 8'h05, "R6 clear only B");

        // R10 standby resets enables and blocks writes
        standby = 1; cpu_sel = 1; cpu_wr = 1; cpu_wdata = 8'h07; cyc();
        peek(1, 0, 8'hF8, "R10 standby clears enable");
        peek(0, 1, 8'h00, "R10 irqs masked");
        wr_reg(1, 8'h04);
        peek(1, 0, 8'hFC, "R10 writable after standby");

        cyc(); cyc();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule